// File: doc/BRIEF.md
# Ultra DMA Data-In Host Receiver

This block is the host end of an Ultra DMA read burst, the kind where the attached drive sends data to the host. Software or a sequencer loads a transfer mode (0 to 4) and a word count, then pulses a start input. The block waits for the drive's transfer request and answers with its active-low acknowledge. While request and acknowledge are both asserted, three control wires change meaning: a host-driven halt line, an active-low host-ready line, and a drive-driven strobe. The drive toggles the strobe once per 16-bit word, and both of its edges carry data.

The strobe and the data bus are brought into the host clock through a short synchronizer. Every detected strobe transition pushes one word into a small receive FIFO, and a downstream consumer drains that FIFO through a valid/pop port. When the FIFO has only a few free slots left, the host withdraws its ready signal. The drive may still send up to two more words after that, and the reserved slots hold them. When the programmed count has been captured, the host withdraws ready, waits the mode's ready-to-stop time, and raises halt. It then waits for the drive to drop its request before it releases the acknowledge. All protocol times are nanosecond figures that are turned into clock counts with a ceiling, using a clock-period parameter.

Top module: `udma_rx_host`

## Requirements
- R1: After reset, `xfer_ack_n_o`=1, `ready_n_o`=1, `halt_o`=0, `busy_o`=0 and `pop_valid_o`=0.
- R2: After `start_i`, `busy_o` is 1. `xfer_ack_n_o` stays 1 until `xfer_req_i` has been seen high, and it goes low only after a cycle in which `xfer_req_i` was 1.
- R3: When acknowledge is first asserted, `halt_o`=1 and `ready_n_o`=1. These hold for exactly ceil(20 ns / CLK_NS) cycles (2 at 10 ns). Then `ready_n_o` and `halt_o` both drop to 0 together.
- R4: While the bus is remapped (`xfer_req_i`=1 and `xfer_ack_n_o`=0), every transition of `strobe_i`, rising or falling, captures `bus_data_i` into the FIFO. `pop_data_o` presents the words in arrival order. A word leaves when `pop_valid_o` and `pop_i` are both 1 at a clock edge.
- R5: `ready_n_o` rises as soon as FIFO free space is ≤ PAUSE_FREE (3). With depth 8, that happens after 5 unread words. It falls again once free space exceeds 3.
- R6: Words that arrive after `ready_n_o` has risen (at least two) are all stored and delivered in order. The FIFO is never written while full.
- R7: Strobe transitions are ignored while the bus is not remapped, whether the block is idle or the acknowledge is negated. No FIFO entry appears.
- R8: Once `words_i` words have been captured, `ready_n_o` rises. `halt_o` then rises exactly tRP cycles later, where tRP = ceil(160, 125, 100, 100, 100 ns / CLK_NS) for modes 0 to 4 (16, 13, 10, 10, 10 at 10 ns). It also rises no sooner than ceil(50 ns / CLK_NS) cycles after the last captured word.
- R9: `xfer_ack_n_o` stays 0 until `xfer_req_i` is low. After that it rises 2 to 3 cycles after the drop, which covers a 20 ns hold. `busy_o` falls in the same cycle.
- R10: If `xfer_req_i` drops in the middle of a burst, the next cycle has `ready_n_o`=1 and `halt_o`=1. The release then follows R9, and every word already captured stays readable.
- R11: A mode value above 4 is treated as mode 4.
- R12: `mode_i` and `words_i` are sampled only on the `start_i` cycle. Changing them later has no effect on the running burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | One-cycle pulse that opens a burst while idle |
| mode_i | input | 3 | Transfer mode 0..4; values above 4 clamp to 4 |
| words_i | input | 16 | Number of words to receive before the host stops |
| busy_o | output | 1 | High from start until acknowledge is released |
| xfer_req_i | input | 1 | Drive's transfer request, active high |
| xfer_ack_n_o | output | 1 | Host acknowledge, active low |
| halt_o | output | 1 | Host stop request (write-strobe wire during a burst), active high |
| ready_n_o | output | 1 | Host ready (read-strobe wire during a burst), active low |
| strobe_i | input | 1 | Drive data strobe (ready wire during a burst), both edges valid |
| bus_data_i | input | 16 | Drive data bus |
| pop_i | input | 1 | Consumer takes the head word |
| pop_valid_o | output | 1 | FIFO holds at least one word |
| pop_data_o | output | 16 | Head word of the FIFO |

## Verification
A controller stuck in the wrong state shows up at the ports within one or two cycles. Ready can fail to fall after the setup window. Halt can rise while data is still expected. The acknowledge can stay low after the drive leaves, and the mismatch in the ready-to-halt gap measured by the bench exposes it. A wrong FIFO occupancy or a wrong pointer first appears as a ready signal that rises after the wrong word of a stalled burst. It can also appear as a scoreboard mismatch on the next popped word, which catches lost in-flight words and reordered words. A capture path that ignores one strobe edge, or accepts edges outside the remapped window, changes the number of words delivered, and the end-of-test queue check sees it.

// File: rtl/udma_rx_pkg.sv
// Package: shared state type and protocol-time helpers for the Ultra DMA
// data-in receiver. Times are in nanoseconds; the helpers convert them to
// clock counts with a ceiling so that every wait is at least as long as the
// protocol minimum.
package udma_rx_pkg;

    localparam int NUM_MODES   = 5;
    localparam int SETUP_NS    = 20;   // acknowledge setup and envelope minimum
    localparam int ACK_HOLD_NS = 20;   // acknowledge hold after request drops
    localparam int SS_NS       = 50;   // last strobe edge to stop request

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WAIT_REQ,
        ST_ACK,
        ST_READY,
        ST_RECEIVE,
        ST_PAUSE,
        ST_STOP,
        ST_RELEASE
    } rx_state_e;

    // Ready-negated-to-stop minimum per mode; higher codes reuse the fastest.
    function automatic int rp_ns(input int mode);
        if (mode == 0)      return 160;
        else if (mode == 1) return 125;
        else                return 100;
    endfunction

    // Ceiling conversion of a time in ns to whole clock cycles.
    function automatic int cyc_ceil(input int ns, input int clk_ns);
        return (ns + clk_ns - 1) / clk_ns;
    endfunction

endpackage

// File: rtl/udma_rx_sync.sv
// Module: udma_rx_sync
// Brings the drive strobe and data bus into the host clock. The strobe
// passes through SYNC_STAGES flops plus one more for edge detection, and the
// data passes through SYNC_STAGES flops, so the word presented with edge_o
// was sampled in the same cycle as the strobe transition that marks it.
// Assumes: the drive holds data stable for at least one host clock around
// each strobe transition, and transitions are at least two clocks apart.
module udma_rx_sync #(
    parameter int DATA_W      = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              strobe_i,
    input  logic [DATA_W-1:0] data_i,
    output logic              edge_o,
    output logic [DATA_W-1:0] data_o
);

    logic [SYNC_STAGES:0] stb_q;
    logic [DATA_W-1:0]    dat_q [SYNC_STAGES];

    // Strobe synchronizer chain with one extra stage for edge compare.
    always_ff @(posedge clk) begin
        if (!rst_n) stb_q <= '0;
        else        stb_q <= {stb_q[SYNC_STAGES-1:0], strobe_i};
    end

    // Data pipeline, first stage samples the bus.
    always_ff @(posedge clk) begin
        if (!rst_n) dat_q[0] <= '0;
        else        dat_q[0] <= data_i;
    end

    for (genvar s = 1; s < SYNC_STAGES; s++) begin : g_dat
        // Data pipeline, later stages track the strobe chain depth.
        always_ff @(posedge clk) begin
            if (!rst_n) dat_q[s] <= '0;
            else        dat_q[s] <= dat_q[s-1];
        end
    end

    assign edge_o = stb_q[SYNC_STAGES] ^ stb_q[SYNC_STAGES-1];
    assign data_o = dat_q[SYNC_STAGES-1];

endmodule

// File: rtl/udma_rx_fifo.sv
// Module: udma_rx_fifo
// Receive FIFO between the capture path and the consumer. It reports its
// free space so the controller can withdraw ready early. A push is
// refused while full; a pop while empty is ignored.
// Assumes: DEPTH >= 2.
module udma_rx_fifo #(
    parameter int DATA_W = 16,
    parameter int DEPTH  = 8,
    localparam int PTR_W  = $clog2(DEPTH),
    localparam int FILL_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push_i,
    input  logic [DATA_W-1:0] data_i,
    input  logic              pop_i,
    output logic              valid_o,
    output logic [DATA_W-1:0] data_o,
    output logic [FILL_W-1:0] free_o
);

    localparam logic [FILL_W-1:0] FULL_LVL = FILL_W'(DEPTH);
    localparam logic [PTR_W-1:0]  LAST_PTR = PTR_W'(DEPTH - 1);

    logic [DATA_W-1:0] mem [DEPTH];
    logic [PTR_W-1:0]  wr_ptr, rd_ptr;
    logic [FILL_W-1:0] fill;
    logic              do_push, do_pop;

    assign do_push = push_i && (fill != FULL_LVL);
    assign do_pop  = pop_i && (fill != '0);

    // Storage write; contents need no reset.
    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= data_i;
    end

    // Pointer and occupancy bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            fill   <= '0;
        end else begin
            if (do_push) wr_ptr <= (wr_ptr == LAST_PTR) ? '0 : wr_ptr + 1'b1;
            if (do_pop)  rd_ptr <= (rd_ptr == LAST_PTR) ? '0 : rd_ptr + 1'b1;
            case ({do_push, do_pop})
                2'b10:   fill <= fill + 1'b1;
                2'b01:   fill <= fill - 1'b1;
                default: fill <= fill;
            endcase
        end
    end

    assign valid_o = (fill != '0);
    assign data_o  = mem[rd_ptr];
    assign free_o  = FULL_LVL - fill;

    // R6
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        push_i |-> (fill != FULL_LVL))
        else $error("capture arrived with the FIFO full");

endmodule

// File: rtl/udma_rx_ctrl.sv
// Module: udma_rx_ctrl
// Burst sequencer: request/acknowledge handshake, ready pause and resume
// driven by FIFO free space, count-based stop after the mode's
// ready-to-stop time, and release of the acknowledge once the drive drops
// its request. Mode timings come from a table built by generate.
// Assumes: xfer_req_i is already synchronous to clk.
module udma_rx_ctrl
    import udma_rx_pkg::*;
#(
    parameter int CLK_NS     = 10,
    parameter int WORD_W     = 16,
    parameter int MODE_W     = 3,
    parameter int FILL_W     = 4,
    parameter int PAUSE_FREE = 3,
    parameter int TMR_W      = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [MODE_W-1:0] mode_i,
    input  logic [WORD_W-1:0] words_i,
    input  logic              xfer_req_i,
    input  logic              push_i,
    input  logic [FILL_W-1:0] free_i,
    output logic              busy_o,
    output logic              ack_n_o,
    output logic              halt_o,
    output logic              ready_n_o,
    output logic              active_o
);

    localparam logic [TMR_W-1:0]  SETUP_LAST = TMR_W'(cyc_ceil(SETUP_NS, CLK_NS) - 1);
    localparam logic [TMR_W-1:0]  HOLD_LAST  = TMR_W'(cyc_ceil(ACK_HOLD_NS, CLK_NS) - 1);
    localparam logic [TMR_W-1:0]  SS_LAST    = TMR_W'(cyc_ceil(SS_NS, CLK_NS) - 1);
    localparam logic [MODE_W-1:0] TOP_MODE   = MODE_W'(NUM_MODES - 1);
    localparam logic [FILL_W-1:0] PAUSE_LVL  = FILL_W'(PAUSE_FREE);

    rx_state_e         state_q, state_d;
    logic [MODE_W-1:0] mode_q;
    logic [WORD_W-1:0] words_q, got_q;
    logic [TMR_W-1:0]  tmr_q, gap_q;
    logic [TMR_W-1:0]  rp_tab [2**MODE_W];
    logic [TMR_W-1:0]  rp_cyc;
    logic              count_done, room_low, tmr_clr;

    // Ready-to-stop cycle count for every mode code (higher codes clamp).
    for (genvar g = 0; g < 2**MODE_W; g++) begin : g_rp
        assign rp_tab[g] = TMR_W'(cyc_ceil(rp_ns(g), CLK_NS));
    end

    assign rp_cyc     = rp_tab[mode_q];
    assign count_done = (got_q >= words_q);
    assign room_low   = (free_i <= PAUSE_LVL);

    // Next-state selection.
    always_comb begin
        state_d = state_q;
        case (state_q)
            ST_IDLE:     if (start_i) state_d = ST_WAIT_REQ;
            ST_WAIT_REQ: if (xfer_req_i) state_d = ST_ACK;
            ST_ACK:      if (tmr_q >= SETUP_LAST) state_d = ST_READY;
            ST_READY:    state_d = ST_RECEIVE;
            ST_RECEIVE: begin
                if (!xfer_req_i)    state_d = ST_RELEASE;
                else if (count_done) state_d = ST_STOP;
                else if (room_low)  state_d = ST_PAUSE;
            end
            ST_PAUSE: begin
                if (!xfer_req_i)    state_d = ST_RELEASE;
                else if (count_done) state_d = ST_STOP;
                else if (!room_low) state_d = ST_RECEIVE;
            end
            ST_STOP: begin
                if (!xfer_req_i) state_d = ST_RELEASE;
                else if ((tmr_q >= rp_cyc - 1'b1) && (gap_q >= SS_LAST))
                    state_d = ST_RELEASE;
            end
            ST_RELEASE: if (!xfer_req_i && (tmr_q >= HOLD_LAST)) state_d = ST_IDLE;
            default:     state_d = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Burst parameters latched once per start; mode clamped to the top mode.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q  <= '0;
            words_q <= '0;
        end else if (state_q == ST_IDLE && start_i) begin
            mode_q  <= (mode_i > TOP_MODE) ? TOP_MODE : mode_i;
            words_q <= words_i;
        end
    end

    // Count of words captured in the current burst.
    always_ff @(posedge clk) begin
        if (!rst_n)                               got_q <= '0;
        else if (state_q == ST_IDLE && start_i)   got_q <= '0;
        else if (push_i)                          got_q <= got_q + 1'b1;
    end

    // State dwell timer; restarts on entry and while the release waits.
    assign tmr_clr = (state_d != state_q) || (state_q == ST_RELEASE && xfer_req_i);
    always_ff @(posedge clk) begin
        if (!rst_n || tmr_clr)   tmr_q <= '0;
        else if (tmr_q != '1)    tmr_q <= tmr_q + 1'b1;
    end

    // Cycles since the last captured word, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n || push_i)    gap_q <= '0;
        else if (gap_q != '1)    gap_q <= gap_q + 1'b1;
    end

    // Output decode from the registered state.
    always_comb begin
        ack_n_o   = 1'b0;
        halt_o    = 1'b0;
        ready_n_o = 1'b1;
        case (state_q)
            ST_IDLE, ST_WAIT_REQ: ack_n_o = 1'b1;
            ST_ACK, ST_RELEASE:   halt_o = 1'b1;
            ST_READY, ST_RECEIVE: ready_n_o = 1'b0;
            default:              ;
        endcase
    end

    assign busy_o   = (state_q != ST_IDLE);
    assign active_o = xfer_req_i && !ack_n_o;

    // Checker counters: cycles since acknowledge fell and since ready rose.
    logic [TMR_W-1:0] ack_age, rp_age;
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ack_age <= '0;
            rp_age  <= '0;
        end else begin
            ack_age <= ack_n_o ? '0 : ((ack_age != '1) ? ack_age + 1'b1 : ack_age);
            rp_age  <= !ready_n_o ? '0 : ((rp_age != '1) ? rp_age + 1'b1 : rp_age);
        end
    end

    // R2
    ack_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ack_n_o) |-> $past(xfer_req_i))
        else $error("acknowledge asserted without a request");

    // R3
    setup_before_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ready_n_o) |-> (ack_age > SETUP_LAST))
        else $error("ready asserted before the setup window elapsed");

    // R8
    stop_after_rp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(halt_o) && state_q == ST_RELEASE && xfer_req_i) |-> (rp_age >= rp_cyc))
        else $error("stop raised too soon after ready was withdrawn");

    // R9
    ack_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ack_n_o) |-> $past(!xfer_req_i))
        else $error("acknowledge released while the request was still high");

endmodule

// File: rtl/udma_rx_host.sv
// Module: udma_rx_host (top)
// Ultra DMA data-in host receiver: strobe/data synchronizer, receive FIFO
// and burst sequencer. A word is pushed on every synchronized strobe
// transition, but only while request and acknowledge are both asserted.
// Assumes: FIFO_DEPTH > PAUSE_FREE + 2 so in-flight words always fit.
module udma_rx_host #(
    parameter int DATA_W      = 16,
    parameter int WORD_W      = 16,
    parameter int MODE_W      = 3,
    parameter int FIFO_DEPTH  = 8,
    parameter int PAUSE_FREE  = 3,
    parameter int CLK_NS      = 10,
    parameter int SYNC_STAGES = 2,
    parameter int TMR_W       = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [MODE_W-1:0] mode_i,
    input  logic [WORD_W-1:0] words_i,
    output logic              busy_o,
    input  logic              xfer_req_i,
    output logic              xfer_ack_n_o,
    output logic              halt_o,
    output logic              ready_n_o,
    input  logic              strobe_i,
    input  logic [DATA_W-1:0] bus_data_i,
    input  logic              pop_i,
    output logic              pop_valid_o,
    output logic [DATA_W-1:0] pop_data_o
);

    localparam int FILL_W = $clog2(FIFO_DEPTH + 1);

    logic              stb_edge, bus_active, cap_push;
    logic [DATA_W-1:0] cap_data;
    logic [FILL_W-1:0] fifo_free;

    udma_rx_sync #(
        .DATA_W      (DATA_W),
        .SYNC_STAGES (SYNC_STAGES)
    ) sync_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .strobe_i (strobe_i),
        .data_i   (bus_data_i),
        .edge_o   (stb_edge),
        .data_o   (cap_data)
    );

    assign cap_push = stb_edge && bus_active;

    udma_rx_fifo #(
        .DATA_W (DATA_W),
        .DEPTH  (FIFO_DEPTH)
    ) fifo_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .push_i  (cap_push),
        .data_i  (cap_data),
        .pop_i   (pop_i),
        .valid_o (pop_valid_o),
        .data_o  (pop_data_o),
        .free_o  (fifo_free)
    );

    udma_rx_ctrl #(
        .CLK_NS     (CLK_NS),
        .WORD_W     (WORD_W),
        .MODE_W     (MODE_W),
        .FILL_W     (FILL_W),
        .PAUSE_FREE (PAUSE_FREE),
        .TMR_W      (TMR_W)
    ) ctrl_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start_i),
        .mode_i     (mode_i),
        .words_i    (words_i),
        .xfer_req_i (xfer_req_i),
        .push_i     (cap_push),
        .free_i     (fifo_free),
        .busy_o     (busy_o),
        .ack_n_o    (xfer_ack_n_o),
        .halt_o     (halt_o),
        .ready_n_o  (ready_n_o),
        .active_o   (bus_active)
    );

    // R7
    idle_no_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |=> !$rose(pop_valid_o))
        else $error("word captured while no burst was open");

endmodule

// File: tb/udma_rx_host_tb_top.sv
// Bench: the drive model sends words and queues each one as expected data.
// A monitor pops the queue and compares it with every word the design
// delivers. Inputs change one time unit after a rising edge; outputs are
// sampled on falling edges.
module udma_rx_host_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int SETUP_CYC  = 2;

    logic        clk, rst_n, start_i, xfer_req_i, strobe_i, pop_i;
    logic [2:0]  mode_i;
    logic [15:0] words_i, bus_data_i;
    logic        busy_o, xfer_ack_n_o, halt_o, ready_n_o, pop_valid_o;
    logic [15:0] pop_data_o;

    int          n_vec, n_bad, last_rp, rp_ctr;
    logic        halt_prev, done;
    logic [15:0] exp_q [$];

    udma_rx_host dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .mode_i(mode_i),
        .words_i(words_i), .busy_o(busy_o), .xfer_req_i(xfer_req_i),
        .xfer_ack_n_o(xfer_ack_n_o), .halt_o(halt_o), .ready_n_o(ready_n_o),
        .strobe_i(strobe_i), .bus_data_i(bus_data_i), .pop_i(pop_i),
        .pop_valid_o(pop_valid_o), .pop_data_o(pop_data_o)
    );

    initial clk = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int exp_rp(input int mode);
        int m, ns;
        m  = (mode > 4) ? 4 : mode;
        ns = (m == 0) ? 160 : (m == 1) ? 125 : 100;
        return (ns + CLK_PERIOD - 1) / CLK_PERIOD;
    endfunction

    // Scoreboard monitor (R4): every delivered word must match the queue head.
    always @(negedge clk) begin
        if (rst_n && pop_valid_o && pop_i) begin
            if (exp_q.size() == 0) check(1'b0, "R4 unexpected word", int'(pop_data_o), -1);
            else begin
                logic [15:0] e;
                e = exp_q.pop_front();
                check(pop_data_o == e, "R4 data order", int'(pop_data_o), int'(e));
            end
        end
    end

    // Ready-rise to halt-rise gap tracker for R8.
    always @(negedge clk) begin
        if (!rst_n) begin
            rp_ctr = 0; halt_prev = 1'b0; last_rp = -1;
        end else begin
            if (!ready_n_o) rp_ctr = 0;
            else begin
                if (halt_o && !halt_prev) last_rp = rp_ctr;
                rp_ctr++;
            end
            halt_prev = halt_o;
        end
    end

    task automatic tick();
        @(posedge clk); #1;
    endtask

    task automatic toggle_strobe(input logic [15:0] w);
        tick(); bus_data_i = w;
        tick(); strobe_i = ~strobe_i;
        repeat (5) @(posedge clk);
    endtask

    task automatic send_word(input logic [15:0] w);
        exp_q.push_back(w);
        toggle_strobe(w);
    endtask

    task automatic open_burst(input int mode, input int n, input bit alter);
        int gap;
        tick(); mode_i = 3'(mode); words_i = 16'(n); start_i = 1'b1;
        tick(); start_i = 1'b0;
        if (alter) begin mode_i = 3'd4; words_i = 16'd3; end   // R12 stimulus
        repeat (3) tick();
        @(negedge clk);
        check(xfer_ack_n_o == 1'b1 && busy_o == 1'b1, "R2 no ack before request",
              int'(xfer_ack_n_o), 1);
        tick(); xfer_req_i = 1'b1;
        gap = 0;
        for (int k = 0; k < 50; k++) begin
            @(negedge clk);
            if (!ready_n_o) break;
            if (!xfer_ack_n_o) begin
                if (!halt_o) check(1'b0, "R3 halt during setup", int'(halt_o), 1);
                gap++;
            end
        end
        check(gap == SETUP_CYC, "R3 setup cycles", gap, SETUP_CYC);
        check(halt_o == 1'b0 && ready_n_o == 1'b0, "R3 ready with halt low", int'(halt_o), 0);
    endtask

    task automatic close_burst(input int mode);
        int hold;
        for (int k = 0; k < 100; k++) begin
            @(negedge clk);
            if (halt_o) break;
        end
        @(negedge clk);
        check(last_rp == exp_rp(mode), "R8 ready-to-halt cycles", last_rp, exp_rp(mode));
        check(xfer_ack_n_o == 1'b0, "R9 ack held while request high", int'(xfer_ack_n_o), 0);
        tick(); xfer_req_i = 1'b0;
        hold = 0;
        for (int k = 0; k < 20; k++) begin
            @(negedge clk);
            if (xfer_ack_n_o) break;
            hold++;
        end
        check(hold >= 2 && hold <= 3, "R9 ack hold after request drop", hold, 2);
        check(busy_o == 1'b0, "R9 busy cleared", int'(busy_o), 0);
    endtask

    initial begin
        n_vec = 0; n_bad = 0; done = 1'b0;
        rst_n = 1'b0; start_i = 1'b0; xfer_req_i = 1'b0; strobe_i = 1'b0;
        pop_i = 1'b1; mode_i = '0; words_i = '0; bus_data_i = '0;
        repeat (3) tick();
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(xfer_ack_n_o == 1'b1, "R1 ack", int'(xfer_ack_n_o), 1);
        check(ready_n_o == 1'b1 && halt_o == 1'b0, "R1 ready/halt", int'(ready_n_o), 1);
        check(busy_o == 1'b0 && pop_valid_o == 1'b0, "R1 busy/valid", int'(busy_o), 0);

        // R7: strobes while idle, then with request high but no acknowledge
        for (int i = 0; i < 4; i++) toggle_strobe(16'h0BAD + 16'(i));
        tick(); xfer_req_i = 1'b1;
        for (int i = 0; i < 2; i++) toggle_strobe(16'h0DEF + 16'(i));
        @(negedge clk);
        check(pop_valid_o == 1'b0, "R7 no capture outside burst", int'(pop_valid_o), 0);
        check(xfer_ack_n_o == 1'b1, "R2 no ack without start", int'(xfer_ack_n_o), 1);
        tick(); xfer_req_i = 1'b0;

        // Plain burst, mode 1 (R4, R8 with 13 cycles)
        open_burst(1, 4, 1'b0);
        for (int i = 0; i < 4; i++) send_word(16'hA100 + 16'(i));
        close_burst(1);

        // Stalled consumer, mode 0, parameters altered after start (R5, R6, R12)
        pop_i = 1'b0;
        open_burst(0, 10, 1'b1);
        for (int i = 0; i < 5; i++) begin
            send_word(16'hB200 + 16'(i));
            @(negedge clk);
            check(ready_n_o == (i == 4), "R5 pause point", int'(ready_n_o), int'(i == 4));
        end
        send_word(16'hB205);
        send_word(16'hB206);
        @(negedge clk);
        check(ready_n_o == 1'b1 && pop_valid_o == 1'b1, "R6 in-flight words while paused",
              int'(ready_n_o), 1);
        tick(); pop_i = 1'b1;
        for (int k = 0; k < 10; k++) begin
            @(negedge clk);
            if (!ready_n_o) break;
        end
        check(ready_n_o == 1'b0, "R5 resume after drain", int'(ready_n_o), 0);
        for (int i = 7; i < 10; i++) send_word(16'hB200 + 16'(i));
        close_burst(0);
        check(exp_q.size() == 0, "R6 all paused words delivered", exp_q.size(), 0);

        // Mode code 7 clamps to mode 4 (R11)
        open_burst(7, 3, 1'b0);
        for (int i = 0; i < 3; i++) send_word(16'hC300 + 16'(i));
        close_burst(4);

        // Drive ends the burst early (R10)
        open_burst(2, 8, 1'b0);
        for (int i = 0; i < 3; i++) send_word(16'hD400 + 16'(i));
        tick(); xfer_req_i = 1'b0;
        @(negedge clk);
        @(negedge clk);
        check(ready_n_o == 1'b1 && halt_o == 1'b1, "R10 stop after request drop",
              int'(halt_o), 1);
        for (int k = 0; k < 10; k++) begin
            @(negedge clk);
            if (!busy_o) break;
        end
        check(busy_o == 1'b0 && xfer_ack_n_o == 1'b1, "R10 released", int'(busy_o), 0);
        repeat (4) @(negedge clk);
        check(exp_q.size() == 0, "R10 captured words readable", exp_q.size(), 0);
        check(pop_valid_o == 1'b0, "R4 FIFO drained", int'(pop_valid_o), 0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_vec++; n_bad++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

endmodule